// File: doc/BRIEF.md
# ADC Result Buffer with Sticky Error Flags

This block sits between an analog-to-digital converter and a host register bus. It holds conversion results until the host collects them. A one-cycle start pulse launches a conversion. An internal down-counter stands in for the converter's busy time. When that count runs out, the value on the converter data input is captured into a 512-entry first-in first-out store.

The host sees three things. The first is a 16-bit status word with a not-empty flag and two sticky error bits. One error bit records results lost to a full store. The other records a start that arrived while a conversion was still running. The second is the oldest stored result, presented on the data output. The third is a busy indication.

A read strobe removes the oldest entry. A clear strobe drops both error bits, empties the store and abandons any conversion in flight. With a 250 MHz clock, a conversion time of 2500 cycles gives the usual ten-microsecond conversion.

Top module: `adc_result_buffer`

## Requirements
- R1: After reset, the status word is all zeros, the store is empty and `busy_o` is low.
- R2: Status bit 0 (not-empty) is 1 exactly when one or more results are stored. It falls in the cycle after a read that takes the last entry.
- R3: `data_o` always shows the oldest stored result. A `data_rd_i` pulse while the store is non-empty removes that entry, so results leave in the order they were captured.
- R4: A `data_rd_i` pulse while the store is empty changes no stored entry and no count. With the default configuration, `data_o` reads zero while the store is empty.
- R5: When a conversion completes while 512 results are stored and no read occurs in the same cycle, the result is discarded. Status bit 1 (overflow) is then set and stays set until a clear.
- R6: A `conv_start_i` pulse while `busy_o` is high sets status bit 2 (overrun), which stays set until a clear. The conversion in progress keeps its original completion time, and no new conversion is launched.
- R7: A `clear_i` pulse resets status bits 1 and 2, empties the store and ends any conversion in progress. It takes priority over a start or a read in the same cycle.
- R8: A start accepted at a clock edge makes `busy_o` high from that edge. It captures `conv_data_i` at the edge N cycles later, where N is `conv_cycles_i` sampled at the start, and a value of 0 is treated as 1. The result and the not-empty bit are visible right after that edge, and `busy_o` is low again.
- R9: A conversion completing in the same cycle as a read on a full store is accepted. The count stays 512 and overflow is not set.
- R10: Status bits 15 down to 3 always read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| conv_start_i | input | 1 | One-cycle conversion start pulse |
| conv_cycles_i | input | 16 | Conversion time in cycles, sampled at an accepted start |
| conv_data_i | input | 16 | Converter result, captured at completion |
| data_rd_i | input | 1 | Host read of the data register; pops one entry |
| clear_i | input | 1 | Host strobe of the clear register |
| data_o | output | 16 | Oldest stored result |
| status_o | output | 16 | Status word: bit 0 not-empty, bit 1 overflow, bit 2 overrun |
| busy_o | output | 1 | A conversion is in progress |

## Verification
Isolated conversions with several conversion times, including zero, tell a correct completion edge apart from one early or late by a cycle. Runs of captures followed by runs of reads expose ordering and pointer-wrap faults. Back-to-back starts, a fill to 512 followed by a completion with and without a coincident read, and a clear coinciding with a start and a read each separate one error-flag rule from its neighbours. A long random mix of starts, reads and clears is compared cycle by cycle against a queue-based model, which catches interactions that the directed cases miss.

// File: rtl/adc_buf_pkg.sv
package adc_buf_pkg;
   localparam int STATUS_W    = 16;
   localparam int ST_NE_BIT   = 0;
   localparam int ST_OVF_BIT  = 1;
   localparam int ST_OVR_BIT  = 2;

   typedef struct packed {
      logic overrun;
      logic overflow;
      logic not_empty;
   } status_bits_t;
endpackage

// File: rtl/adc_conv_timer.sv
module adc_conv_timer #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             abort_i,
   input  logic [CNT_W-1:0] cycles_i,
   output logic             busy_o,
   output logic             done_o,
   output logic             overrun_o
);
   logic             busy_q;
   logic [CNT_W-1:0] left_q;

   assign busy_o    = busy_q;
   assign done_o    = busy_q && (left_q == '0);
   assign overrun_o = start_i && busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         left_q <= '0;
      end else if (abort_i) begin
         busy_q <= 1'b0;
         left_q <= '0;
      end else if (done_o) begin
         busy_q <= 1'b0;
      end else if (busy_q) begin
         left_q <= left_q - 1'b1;
      end else if (start_i) begin
         busy_q <= 1'b1;
         left_q <= (cycles_i == '0) ? '0 : cycles_i - 1'b1;
      end
   end

   AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !busy_o); // R8
   AST_OVERRUN_KEEPS_TIME: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && busy_q && !done_o && !abort_i) |=> (busy_q && left_q == CNT_W'($past(left_q) - 1'b1))); // R6
endmodule

// File: rtl/adc_fifo_store.sv
module adc_fifo_store #(
   parameter int DATA_W     = 16,
   parameter int DEPTH      = 512,
   parameter bit ZERO_EMPTY = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push_i,
   input  logic [DATA_W-1:0] data_i,
   input  logic              pop_i,
   input  logic              flush_i,
   output logic [DATA_W-1:0] head_o,
   output logic              not_empty_o,
   output logic              drop_o
);
   localparam int AW = $clog2(DEPTH);
   localparam int CW = AW + 1;
   localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

   logic [DATA_W-1:0] mem [DEPTH];
   logic [AW-1:0]     wr_ptr_q, rd_ptr_q;
   logic [CW-1:0]     count_q;
   logic              pop_ok, push_ok;

   assign pop_ok      = pop_i && (count_q != '0) && !flush_i;
   assign push_ok     = push_i && !flush_i && ((count_q != FULL_CNT) || pop_ok);
   assign drop_o      = push_i && !flush_i && !push_ok;
   assign not_empty_o = (count_q != '0);

   always_ff @(posedge clk) begin
      if (push_ok) mem[wr_ptr_q] <= data_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr_q <= '0;
         rd_ptr_q <= '0;
         count_q  <= '0;
      end else if (flush_i) begin
         wr_ptr_q <= '0;
         rd_ptr_q <= '0;
         count_q  <= '0;
      end else begin
         if (push_ok) wr_ptr_q <= wr_ptr_q + 1'b1;
         if (pop_ok)  rd_ptr_q <= rd_ptr_q + 1'b1;
         case ({push_ok, pop_ok})
            2'b10:   count_q <= count_q + 1'b1;
            2'b01:   count_q <= count_q - 1'b1;
            default: count_q <= count_q;
         endcase
      end
   end

   generate
      if (ZERO_EMPTY) begin : g_zero_head
         assign head_o = not_empty_o ? mem[rd_ptr_q] : '0;
      end else begin : g_raw_head
         assign head_o = mem[rd_ptr_q];
      end
   endgenerate

   AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      count_q <= FULL_CNT); // R5
   AST_EMPTY_READ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (count_q == '0 && pop_i && !push_i && !flush_i) |=> (count_q == '0 && $stable(rd_ptr_q))); // R4
   AST_FULL_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
      (count_q == FULL_CNT && push_i && pop_i && !flush_i) |=> (count_q == FULL_CNT)); // R9
endmodule

// File: rtl/adc_err_flags.sv
module adc_err_flags (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic ovf_set_i,
   input  logic ovr_set_i,
   output logic ovf_o,
   output logic ovr_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovf_o <= 1'b0;
         ovr_o <= 1'b0;
      end else if (clr_i) begin
         ovf_o <= 1'b0;
         ovr_o <= 1'b0;
      end else begin
         if (ovf_set_i) ovf_o <= 1'b1;
         if (ovr_set_i) ovr_o <= 1'b1;
      end
   end

   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_o && !clr_i) |=> ovf_o); // R5
   AST_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr_set_i && !clr_i) |=> ovr_o); // R6
   AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> (!ovf_o && !ovr_o)); // R7
endmodule

// File: rtl/adc_result_buffer.sv
module adc_result_buffer
   import adc_buf_pkg::*;
#(
   parameter int DATA_W          = 16,
   parameter int DEPTH           = 512,
   parameter int CNT_W           = 16,
   parameter bit ZERO_EMPTY_READ = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                conv_start_i,
   input  logic [CNT_W-1:0]    conv_cycles_i,
   input  logic [DATA_W-1:0]   conv_data_i,
   input  logic                data_rd_i,
   input  logic                clear_i,
   output logic [DATA_W-1:0]   data_o,
   output logic [STATUS_W-1:0] status_o,
   output logic                busy_o
);
   initial begin
      assert (DEPTH >= 2 && (DEPTH & (DEPTH - 1)) == 0)
         else $error("DEPTH must be a power of two");
      assert (DATA_W >= 1 && DATA_W <= STATUS_W)
         else $error("DATA_W out of range");
      assert (CNT_W >= 1 && CNT_W <= 32)
         else $error("CNT_W out of range");
   end

   logic         done, overrun_ev, drop_ev, not_empty;
   logic         ovf, ovr;
   status_bits_t st;

   adc_conv_timer #(.CNT_W(CNT_W)) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (conv_start_i),
      .abort_i   (clear_i),
      .cycles_i  (conv_cycles_i),
      .busy_o    (busy_o),
      .done_o    (done),
      .overrun_o (overrun_ev)
   );

   adc_fifo_store #(
      .DATA_W     (DATA_W),
      .DEPTH      (DEPTH),
      .ZERO_EMPTY (ZERO_EMPTY_READ)
   ) u_store (
      .clk         (clk),
      .rst_n       (rst_n),
      .push_i      (done),
      .data_i      (conv_data_i),
      .pop_i       (data_rd_i),
      .flush_i     (clear_i),
      .head_o      (data_o),
      .not_empty_o (not_empty),
      .drop_o      (drop_ev)
   );

   adc_err_flags u_flags (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr_i     (clear_i),
      .ovf_set_i (drop_ev),
      .ovr_set_i (overrun_ev),
      .ovf_o     (ovf),
      .ovr_o     (ovr)
   );

   assign st = '{overrun: ovr, overflow: ovf, not_empty: not_empty};

   always_comb begin
      status_o             = '0;
      status_o[ST_NE_BIT]  = st.not_empty;
      status_o[ST_OVF_BIT] = st.overflow;
      status_o[ST_OVR_BIT] = st.overrun;
   end

   AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      clear_i |=> (status_o == '0 && !busy_o)); // R7
   AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      status_o[STATUS_W-1:3] == '0); // R10
endmodule

// File: tb/sim_adc_result_buffer.sv
`timescale 1ns/1ps
module sim_adc_result_buffer;
   localparam int DEPTH = 512;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        conv_start_i = 1'b0;
   logic [15:0] conv_cycles_i = 16'd5;
   logic [15:0] conv_data_i = '0;
   logic        data_rd_i = 1'b0;
   logic        clear_i = 1'b0;
   logic [15:0] data_o;
   logic [15:0] status_o;
   logic        busy_o;

   always #2 clk = ~clk;

   adc_result_buffer u0 (
      .clk           (clk),
      .rst_n         (rst_n),
      .conv_start_i  (conv_start_i),
      .conv_cycles_i (conv_cycles_i),
      .conv_data_i   (conv_data_i),
      .data_rd_i     (data_rd_i),
      .clear_i       (clear_i),
      .data_o        (data_o),
      .status_o      (status_o),
      .busy_o        (busy_o)
   );

   int nchecks = 0;
   int nfail   = 0;
   bit finished = 1'b0;

   logic [15:0] q[$];
   bit m_ovf, m_ovr, m_busy;
   int m_left;

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      nchecks++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
      end
   endtask

   task automatic compare_all();
      check(status_o[0] == (q.size() != 0), "R2 not-empty", status_o[0], q.size() != 0);
      check(status_o[1] == m_ovf, "R5 overflow", status_o[1], m_ovf);
      check(status_o[2] == m_ovr, "R6 overrun", status_o[2], m_ovr);
      check(status_o[15:3] == 13'd0, "R10 upper bits", status_o[15:3], 0);
      check(busy_o == m_busy, "R8 busy", busy_o, m_busy);
      if (q.size() != 0) check(data_o == q[0], "R3 head data", data_o, q[0]);
      else               check(data_o == 16'd0, "R4 empty data", data_o, 0);
   endtask

   // model of the state after the coming edge, from the state before it
   task automatic model_step(input bit st, input bit rd, input bit clr, input logic [15:0] d);
      bit done, pop;
      if (clr) begin
         q.delete();
         m_ovf = 0; m_ovr = 0; m_busy = 0; m_left = 0;
         return;
      end
      done = m_busy && (m_left == 0);
      pop  = rd && (q.size() != 0);
      if (st && m_busy) m_ovr = 1;
      if (pop) void'(q.pop_front());
      if (done) begin
         if (q.size() < DEPTH) q.push_back(d);
         else m_ovf = 1;
      end
      if (done) m_busy = 0;
      else if (m_busy) m_left--;
      else if (st) begin
         m_busy = 1;
         m_left = (conv_cycles_i == 0) ? 0 : int'(conv_cycles_i) - 1;
      end
   endtask

   task automatic tick(input bit st, input bit rd, input bit clr, input logic [15:0] d);
      conv_start_i = st; data_rd_i = rd; clear_i = clr; conv_data_i = d;
      model_step(st, rd, clr, d);
      @(negedge clk);
      compare_all();
   endtask

   initial begin
      #(4 * 200000);
      if (!finished) begin
         nfail++;
         nchecks++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
         $finish;
      end
   end

   initial begin
      m_ovf = 0; m_ovr = 0; m_busy = 0; m_left = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      check(status_o == 16'd0, "R1 status after reset", status_o, 0);
      check(busy_o == 1'b0, "R1 busy after reset", busy_o, 0);

      // R8: single conversion with N=5, visible exactly after the fifth edge
      conv_cycles_i = 16'd5;
      tick(1, 0, 0, 16'h0000);
      for (int i = 0; i < 4; i++) tick(0, 0, 0, 16'h1111);
      check(status_o[0] == 1'b0, "R8 not visible early", status_o[0], 0);
      tick(0, 0, 0, 16'hA5A5);
      check(status_o[0] == 1'b1 && data_o == 16'hA5A5, "R8 visible on time", data_o, 16'hA5A5);

      // R8: N=0 behaves as 1
      conv_cycles_i = 16'd0;
      tick(1, 0, 0, 16'h0);
      tick(0, 0, 0, 16'h0B0B);
      check(busy_o == 1'b0, "R8 zero cycles as one", busy_o, 0);

      // R3/R2: drain in order
      tick(0, 1, 0, 16'h0);
      check(data_o == 16'h0B0B, "R3 second entry", data_o, 16'h0B0B);
      tick(0, 1, 0, 16'h0);
      check(status_o[0] == 1'b0, "R2 last read clears not-empty", status_o[0], 0);

      // R4: read while empty
      tick(0, 1, 0, 16'h0);
      tick(0, 1, 0, 16'h0);
      check(status_o == 16'd0 && data_o == 16'd0, "R4 empty read no effect", data_o, 0);

      // R6: start while busy
      conv_cycles_i = 16'd4;
      tick(1, 0, 0, 16'h0);
      tick(1, 0, 0, 16'h0);
      check(status_o[2] == 1'b1, "R6 overrun set", status_o[2], 1);
      for (int i = 0; i < 2; i++) tick(0, 0, 0, 16'h0);
      tick(0, 0, 0, 16'h0C0C);
      check(data_o == 16'h0C0C && !busy_o, "R6 original timing kept", data_o, 16'h0C0C);
      tick(0, 0, 1, 16'h0);
      check(status_o == 16'd0, "R7 clear after overrun", status_o, 0);

      // fill to 512 with N=1
      conv_cycles_i = 16'd1;
      for (int i = 0; i < DEPTH; i++) begin
         tick(1, 0, 0, 16'h0);
         tick(0, 0, 0, 16'(i));
      end
      check(status_o[1] == 1'b0 && q.size() == DEPTH, "R5 full no overflow yet", status_o[1], 0);
      // R9: completion with simultaneous read on full
      tick(1, 0, 0, 16'h0);
      tick(0, 1, 0, 16'hBEEF);
      check(status_o[1] == 1'b0, "R9 swap on full no overflow", status_o[1], 0);
      check(data_o == 16'd1, "R9 head advanced", data_o, 1);
      // R5: completion on full without read
      tick(1, 0, 0, 16'h0);
      tick(0, 0, 0, 16'hDEAD);
      check(status_o[1] == 1'b1, "R5 overflow set", status_o[1], 1);
      for (int i = 0; i < 5; i++) tick(0, 0, 0, 16'h0);
      check(status_o[1] == 1'b1, "R5 overflow sticky", status_o[1], 1);
      for (int i = 0; i < DEPTH - 1; i++) tick(0, 1, 0, 16'h0);
      check(data_o == 16'hBEEF, "R5 dropped value absent", data_o, 16'hBEEF);

      // R7: clear aborting conversion, with start and read in same cycle
      conv_cycles_i = 16'd6;
      tick(1, 0, 0, 16'h0);
      tick(0, 0, 0, 16'h0);
      tick(1, 1, 1, 16'h0);
      check(status_o == 16'd0 && busy_o == 1'b0, "R7 clear priority", status_o, 0);
      for (int i = 0; i < 8; i++) tick(0, 0, 0, 16'h7777);
      check(status_o == 16'd0, "R7 aborted result never lands", status_o, 0);

      // random mix compared every cycle
      for (int i = 0; i < 6000; i++) begin
         if (($urandom % 16) == 0) conv_cycles_i = 16'($urandom % 7);
         tick(($urandom % 3) == 0, ($urandom % 4) == 0, ($urandom % 500) == 0, 16'($urandom));
      end

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
      $finish;
   end
endmodule